// File: doc/BRIEF.md
# Branch Condition and Loop-Count Unit

This block decides whether a branch is taken and can update a loop register in the same operation. It takes two register operands, a four-bit condition code and two step controls. When stepping is enabled, the first operand is incremented or decremented before the condition is evaluated. The stepped value is then returned with a write enable, so a loop can be closed by one instruction, for example "add one, then branch while less than".

The conditions are equality, signed and unsigned ordering, and four bitwise tests. The bitwise tests check whether the AND or the OR of the two operands has any bit set, or has no bit set. A parameter selects between a purely combinational path and a single registered output stage. The stage is on by default.

Top module: `brc_unit`

## Requirements
- R1: Condition code 0 (equal) is taken when the updated operand A equals B, and code 1 (not equal) is taken when they differ. Every condition compares the updated operand A, not the original one.
- R2: The signed conditions treat the operands as two's complement. Code 2 (A<B), code 3 (A>=B), code 4 (A<=B) and code 5 (A>B) are each taken exactly when their relation holds.
- R3: The unsigned conditions treat the operands as unsigned. Code 6 (A<B), code 7 (A>=B), code 8 (A<=B) and code 9 (A>B) are each taken exactly when their relation holds.
- R4: Code 10 is taken when (A & B) is nonzero. Code 12 is taken when (A & B) is zero.
- R5: Code 11 is taken when (A | B) is nonzero. Code 13 is taken when (A | B) is zero.
- R6: When step_en is high, A is incremented by one if step_down is 0 and decremented by one if step_down is 1. The result wraps modulo 2^W with no trap. When step_en is low, A passes through unchanged.
- R7: For a valid operation with a legal code and step_en high, wr_en is asserted and wr_data carries the updated A, whether or not the branch is taken. wr_en is low whenever step_en is low.
- R8: Codes 14 and 15 are never taken. They raise illegal and suppress wr_en.
- R9: tgt_sel is high exactly when the operation is valid and taken. With in_valid low, out_valid, taken, tgt_sel, illegal and wr_en are all low.
- R10: With REG_OUT=1, every output appears one clock after its inputs and out_valid follows in_valid by one cycle. While reset is active, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| opnd_a | input | W | Loop / first operand |
| opnd_b | input | W | Second operand |
| cond | input | 4 | Condition code (0 to 15) |
| step_en | input | 1 | Step operand A before comparing |
| step_down | input | 1 | 1 = decrement, 0 = increment |
| out_valid | output | 1 | Result valid |
| taken | output | 1 | Branch decision |
| tgt_sel | output | 1 | Select branch target over fall-through |
| illegal | output | 1 | Unused condition code seen |
| wr_en | output | 1 | Write updated operand back |
| wr_data | output | W | Updated operand A |

## Verification
The assertions assume that in_valid and the control inputs are held at known values while reset is active, so the first post-reset comparison of out_valid against the previous in_valid is meaningful. The bench holds in_valid low throughout reset. It changes inputs only on the falling clock edge, so every registered sample sees stable values. Random operands are drawn mostly from the wrap points (zero, all-ones, the signed extremes) and from B placed next to A. This keeps the equality and ordering boundaries and the step wrap-around inside the sampled space.

// File: rtl/brc_pkg.sv
package brc_pkg;

    typedef enum logic [3:0] {
        BC_EQ   = 4'd0,
        BC_NE   = 4'd1,
        BC_LT   = 4'd2,
        BC_GE   = 4'd3,
        BC_LE   = 4'd4,
        BC_GT   = 4'd5,
        BC_LTU  = 4'd6,
        BC_GEU  = 4'd7,
        BC_LEU  = 4'd8,
        BC_GTU  = 4'd9,
        BC_AND  = 4'd10,
        BC_OR   = 4'd11,
        BC_NAND = 4'd12,
        BC_NOR  = 4'd13,
        BC_RS14 = 4'd14,
        BC_RS15 = 4'd15
    } brc_cond_e;

endpackage

// File: rtl/brc_step.sv
module brc_step #(
    parameter int W = 64
) (
    input  logic [W-1:0] val_i,
    input  logic         en_i,
    input  logic         down_i,
    output logic [W-1:0] val_o
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    always_comb begin
        if (!en_i)
            val_o = val_i;
        else if (down_i)
            val_o = val_i - ONE;   // R6 wraps naturally
        else
            val_o = val_i + ONE;
    end
endmodule

// File: rtl/brc_eval.sv
module brc_eval
    import brc_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [3:0]   cond_i,
    output logic         taken_o,
    output logic         illegal_o
);
    logic      eq, slt, ult, and_nz, or_nz;
    brc_cond_e cc;

    assign cc     = brc_cond_e'(cond_i);
    assign eq     = (a_i == b_i);
    assign slt    = ($signed(a_i) < $signed(b_i));
    assign ult    = (a_i < b_i);
    assign and_nz = |(a_i & b_i);
    assign or_nz  = |(a_i | b_i);

    always_comb begin
        taken_o   = 1'b0;
        illegal_o = 1'b0;
        unique case (cc)
            BC_EQ:   taken_o = eq;
            BC_NE:   taken_o = !eq;
            BC_LT:   taken_o = slt;
            BC_GE:   taken_o = !slt;
            BC_LE:   taken_o = slt || eq;
            BC_GT:   taken_o = !(slt || eq);
            BC_LTU:  taken_o = ult;
            BC_GEU:  taken_o = !ult;
            BC_LEU:  taken_o = ult || eq;
            BC_GTU:  taken_o = !(ult || eq);
            BC_AND:  taken_o = and_nz;
            BC_OR:   taken_o = or_nz;
            BC_NAND: taken_o = !and_nz;
            BC_NOR:  taken_o = !or_nz;
            BC_RS14, BC_RS15: illegal_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/brc_stage.sv
module brc_stage #(
    parameter int W       = 64,
    parameter bit REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         vld_i,
    input  logic         tk_i,
    input  logic         ill_i,
    input  logic         we_i,
    input  logic [W-1:0] wd_i,
    output logic         vld_o,
    output logic         tk_o,
    output logic         ill_o,
    output logic         we_o,
    output logic [W-1:0] wd_o
);
    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vld_o <= 1'b0;
                    tk_o  <= 1'b0;
                    ill_o <= 1'b0;
                    we_o  <= 1'b0;
                    wd_o  <= '0;
                end else begin
                    vld_o <= vld_i;
                    tk_o  <= tk_i;
                    ill_o <= ill_i;
                    we_o  <= we_i;
                    wd_o  <= wd_i;
                end
            end
        end else begin : g_comb
            logic unused_clk;
            assign unused_clk = clk ^ rst_n;
            assign vld_o = vld_i;
            assign tk_o  = tk_i;
            assign ill_o = ill_i;
            assign we_o  = we_i;
            assign wd_o  = wd_i;
        end
    endgenerate
endmodule

// File: rtl/brc_unit.sv
module brc_unit #(
    parameter int W       = 64,
    parameter bit REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  logic [3:0]   cond,
    input  logic         step_en,
    input  logic         step_down,
    output logic         out_valid,
    output logic         taken,
    output logic         tgt_sel,
    output logic         illegal,
    output logic         wr_en,
    output logic [W-1:0] wr_data
);
    logic [W-1:0] a_upd;
    logic         raw_tk, raw_ill;
    logic         nx_tk, nx_ill, nx_we;

    brc_step #(.W(W)) u_step (
        .val_i (opnd_a),
        .en_i  (step_en),
        .down_i(step_down),
        .val_o (a_upd)
    );

    brc_eval #(.W(W)) u_eval (
        .a_i      (a_upd),
        .b_i      (opnd_b),
        .cond_i   (cond),
        .taken_o  (raw_tk),
        .illegal_o(raw_ill)
    );

    assign nx_tk  = in_valid && raw_tk;
    assign nx_ill = in_valid && raw_ill;
    assign nx_we  = in_valid && step_en && !raw_ill;

    brc_stage #(.W(W), .REG_OUT(REG_OUT)) u_stage (
        .clk  (clk),
        .rst_n(rst_n),
        .vld_i(in_valid),
        .tk_i (nx_tk),
        .ill_i(nx_ill),
        .we_i (nx_we),
        .wd_i (a_upd),
        .vld_o(out_valid),
        .tk_o (taken),
        .ill_o(illegal),
        .we_o (wr_en),
        .wd_o (wr_data)
    );

    assign tgt_sel = out_valid && taken;
endmodule

// File: rtl/brc_unit_chk.sv
module brc_unit_chk #(
    parameter bit REG_OUT = 1'b1
) (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic [3:0] cond,
    input logic       step_en,
    input logic       out_valid,
    input logic       taken,
    input logic       tgt_sel,
    input logic       illegal,
    input logic       wr_en
);
    // R8
    ill_not_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!taken && !wr_en));

    // R9
    tgt_needs_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_sel |-> (taken && out_valid));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!taken && !illegal && !wr_en && !tgt_sel));

    generate
        if (REG_OUT) begin : g_lat
            // R10
            vld_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid == $past(in_valid));

            // R7
            we_from_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
                wr_en |-> $past(step_en && in_valid));

            // R8
            ill_from_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
                illegal |-> ($past(cond) >= 4'd14));
        end
    endgenerate
endmodule

bind brc_unit brc_unit_chk #(.REG_OUT(REG_OUT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .cond     (cond),
    .step_en  (step_en),
    .out_valid(out_valid),
    .taken    (taken),
    .tgt_sel  (tgt_sel),
    .illegal  (illegal),
    .wr_en    (wr_en)
);

// File: tb/brc_unit_tb.sv
module brc_unit_tb;
    localparam int W = 64;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] opnd_a = '0;
    logic [W-1:0] opnd_b = '0;
    logic [3:0]   cond = '0;
    logic         step_en = 1'b0;
    logic         step_down = 1'b0;
    logic         out_valid, taken, tgt_sel, illegal, wr_en;
    logic [W-1:0] wr_data;

    int vecs = 0;
    int errs = 0;
    int cyc  = 0;

    always #2.5 clk = ~clk;

    brc_unit #(.W(W), .REG_OUT(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .cond(cond),
        .step_en(step_en), .step_down(step_down),
        .out_valid(out_valid), .taken(taken), .tgt_sel(tgt_sel),
        .illegal(illegal), .wr_en(wr_en), .wr_data(wr_data)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errs = errs + 1;
            $display("FAIL R10 watchdog: actual running expected finished");
            $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

    function automatic logic [W-1:0] f_step(logic [W-1:0] a, logic en, logic dn);
        if (!en) return a;
        return dn ? a - 64'd1 : a + 64'd1;
    endfunction

    function automatic logic f_take(logic [W-1:0] a, logic [W-1:0] b, logic [3:0] c);
        case (c)
            4'd0:  return a == b;
            4'd1:  return a != b;
            4'd2:  return $signed(a) <  $signed(b);
            4'd3:  return $signed(a) >= $signed(b);
            4'd4:  return $signed(a) <= $signed(b);
            4'd5:  return $signed(a) >  $signed(b);
            4'd6:  return a <  b;
            4'd7:  return a >= b;
            4'd8:  return a <= b;
            4'd9:  return a >  b;
            4'd10: return (a & b) != 0;
            4'd11: return (a | b) != 0;
            4'd12: return (a & b) == 0;
            4'd13: return (a | b) == 0;
            default: return 1'b0;
        endcase
    endfunction

    function automatic string f_tag(logic [3:0] c);
        if (c <= 4'd1)  return "R1";
        if (c <= 4'd5)  return "R2";
        if (c <= 4'd9)  return "R3";
        if (c == 4'd10 || c == 4'd12) return "R4";
        if (c <= 4'd13) return "R5";
        return "R8";
    endfunction

    task automatic chk(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
        vecs = vecs + 1;
        if (act !== exp) begin
            errs = errs + 1;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic apply(logic v, logic [W-1:0] a, logic [W-1:0] b, logic [3:0] c,
                         logic se, logic sd);
        logic [W-1:0] au;
        logic         tk, ill;
        @(negedge clk);
        in_valid = v; opnd_a = a; opnd_b = b; cond = c;
        step_en = se; step_down = sd;
        au  = f_step(a, se, sd);
        ill = (c >= 4'd14);
        tk  = v && f_take(au, b, c);
        @(negedge clk);
        // R10 one-cycle latency
        chk("R10", "out_valid", {63'd0, out_valid}, {63'd0, v});
        chk(f_tag(c), "taken", {63'd0, taken}, {63'd0, tk});
        chk("R9", "tgt_sel", {63'd0, tgt_sel}, {63'd0, tk});
        chk("R8", "illegal", {63'd0, illegal}, {63'd0, v && ill});
        chk("R7", "wr_en", {63'd0, wr_en}, {63'd0, v && se && !ill});
        if (v && se && !ill) chk("R6", "wr_data", wr_data, au);
        in_valid = 1'b0;
    endtask

    function automatic logic [W-1:0] pick();
        case ($urandom % 8)
            0: return 64'd0;
            1: return '1;
            2: return 64'h7FFF_FFFF_FFFF_FFFF;
            3: return 64'h8000_0000_0000_0000;
            4: return 64'd1;
            default: return {$urandom, $urandom};
        endcase
    endfunction

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10", "reset out_valid", {63'd0, out_valid}, 64'd0);
        chk("R10", "reset wr_data", wr_data, 64'd0);
        chk("R10", "reset taken", {63'd0, taken}, 64'd0);
        rst_n = 1'b1;

        // R6 wrap corners
        apply(1, '1, 64'd0, 4'd0, 1, 0);                         // R1 -1+1 == 0
        apply(1, 64'd0, '1, 4'd0, 1, 1);                         // R6 0-1 wraps
        apply(1, 64'h7FFF_FFFF_FFFF_FFFF, 64'd0, 4'd2, 1, 0);    // R2 overflow to min
        apply(1, 64'd9, 64'd10, 4'd6, 1, 0);                     // R3 not taken, still written
        apply(1, 64'd3, 64'd4, 4'd14, 1, 0);                     // R8
        apply(1, 64'd3, 64'd4, 4'd15, 0, 0);                     // R8
        apply(1, 64'hF0, 64'h0F, 4'd10, 0, 0);                   // R4
        apply(1, 64'hF0, 64'h0F, 4'd12, 0, 0);                   // R4
        apply(1, 64'd0, 64'd0, 4'd13, 0, 0);                     // R5
        apply(1, 64'd0, 64'd0, 4'd11, 1, 0);                     // R5 stepped
        apply(0, 64'd5, 64'd5, 4'd0, 1, 0);                      // R9 idle

        for (int i = 0; i < 3000; i++) begin
            logic [W-1:0] a, b;
            a = pick();
            case ($urandom % 4)
                0: b = a;
                1: b = a + 64'd1;
                2: b = a - 64'd1;
                default: b = pick();
            endcase
            apply(($urandom % 8) != 0, a, b, 4'($urandom), 1'($urandom), 1'($urandom));
        end

        $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule